// File: doc/BRIEF.md
# 8-bit ALU with Condition Codes

This block is the purely combinational arithmetic and logic unit of an 8-bit accumulator datapath. Each cycle the surrounding core presents an operation code, two 8-bit operands, a separate carry input and the current condition-code byte. The block returns an 8-bit result, a high result byte that is used only by the widening operations, and the next condition-code byte. Each operation follows its own rule for which flags it writes. Every flag it does not write is copied through from the incoming byte.

The operation set covers binary add, subtract and compare, the bitwise operations, bit test and pass-through, clear, invert, two's complement negate, increment and decrement, and shifts and rotates in both directions. It also has a BCD correction step after an add, an 8x8 unsigned multiply and sign extension to 16 bits. Register storage, operand fetch and 16-bit arithmetic are handled by the core around the block.

Condition-code bit positions are fixed because the branch logic of the core decodes them: bit 0 carry (C), bit 1 overflow (V), bit 2 zero (Z), bit 3 negative (N), bit 4 interrupt mask, bit 5 half carry (H), bit 6 fast-interrupt mask, bit 7 entire-state flag.

Top module: `alu8_core`

## Requirements
- R1: `op_sel` codes are ADD=0, ADDC=1, SUB=2, SUBB=3, CMP=4, AND=5, OR=6, XOR=7, TESTBITS=8, PASS=9, TEST=10, CLEAR=11, INVERT=12, NEGATE=13, INCR=14, DECR=15, SHL=16, SAR=17, SHR=18, RCL=19, RCR=20, BCDADJ=21, MUL=22, SEXT=23. Codes 24..31 give `res_lo`=0, `res_hi`=0 and `cc_out`=`cc_in`.
- R2: ADD gives opa+opb and ADDC gives opa+opb+c_in. Both write H (carry out of bit 3), N, Z, V (signed overflow) and C (carry out of bit 7).
- R3: SUB gives opa-opb and SUBB gives opa-opb-c_in. CMP flags opa-opb but returns opa. All three write N, Z, V (signed overflow) and C (borrow), and keep H.
- R4: AND, OR and XOR return the bitwise result. TESTBITS flags opa&opb and returns opa. PASS returns opb and flags it. TEST flags opa and returns it. For all of these N and Z follow the flagged value, V=0, and C is kept.
- R5: CLEAR returns 0 with N=0, Z=1, V=0, C=0.
- R6: INVERT returns ~opa, writes N and Z, and sets V=0 and C=1.
- R7: NEGATE returns (0-opa) mod 256. It sets C=1 exactly when opa is nonzero and V=1 exactly when opa is 80h, and writes N and Z.
- R8: INCR and DECR return opa+1 and opa-1 modulo 256 and write N and Z. V is set only for opa=7Fh (INCR) or opa=80h (DECR). C is kept.
- R9: SHL shifts opa left with a 0 entering bit 0. RCL shifts it left with c_in entering bit 0. Both set C to the old bit 7 and V to the XOR of the old bits 7 and 6, and write N and Z.
- R10: All right shifts set C to the old bit 0 and keep V. SAR keeps bit 7. SHR brings in a 0, so N=0. RCR brings c_in into bit 7. All three write N and Z.
- R11: BCDADJ adds 06h when cc_in H=1 or the low nibble of opa exceeds 9. It adds 60h when cc_in C=1, the high nibble exceeds 9, or the high nibble exceeds 8 while the low nibble exceeds 9. C becomes cc_in C OR the carry out of that addition. N and Z are written and V is kept.
- R12: MUL returns the unsigned product opa*opb with the high byte on `res_hi`. Z=1 exactly when the 16-bit product is 0, C equals bit 7 of the low byte, and N and V are kept.
- R13: SEXT returns opa on `res_lo` and copies of opa bit 7 on `res_hi`. It sets N from opa bit 7 and Z when opa is 0, and keeps V and C.
- R14: Bits 7, 6 and 4 of `cc_out` always equal those of `cc_in`. H changes only under ADD and ADDC. `res_hi` is 0 for every operation except MUL and SEXT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see R1) |
| opa | input | 8 | First operand; the only operand of single-operand operations |
| opb | input | 8 | Second operand |
| c_in | input | 1 | Carry used by ADDC, SUBB, RCL and RCR |
| cc_in | input | 8 | Current condition-code byte |
| res_lo | output | 8 | Result, or low byte of a 16-bit result |
| res_hi | output | 8 | High byte for MUL and SEXT, otherwise 0 |
| cc_out | output | 8 | Next condition-code byte |

## Verification
The bench builds the block with its default 8-bit data width, which is the only width the BCD correction and flag layout support. That width is small enough to sweep every operand pair for each two-operand operation and the multiply. The sweep therefore reaches every signed-overflow boundary, every carry and borrow out of bit 3 and bit 7, and zero products from either side. Single-operand operations run over all 256 values with both carry inputs and six condition-code patterns. These cover each H/C combination the BCD step looks at and every nibble pair around the 9/10 edge. The unused codes are driven as well, to confirm that they leave the flags unchanged.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int NIB   = DW / 2;
    localparam int OPW   = 5;
    localparam int CCW   = 8;
    localparam int NUNIT = 3;

    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;
    localparam int CC_I = 4;
    localparam int CC_H = 5;
    localparam int CC_F = 6;
    localparam int CC_E = 7;

    typedef enum logic [OPW-1:0] {
        OP_ADD      = 5'd0,
        OP_ADDC     = 5'd1,
        OP_SUB      = 5'd2,
        OP_SUBB     = 5'd3,
        OP_CMP      = 5'd4,
        OP_AND      = 5'd5,
        OP_OR       = 5'd6,
        OP_XOR      = 5'd7,
        OP_TESTBITS = 5'd8,
        OP_PASS     = 5'd9,
        OP_TEST     = 5'd10,
        OP_CLEAR    = 5'd11,
        OP_INVERT   = 5'd12,
        OP_NEGATE   = 5'd13,
        OP_INCR     = 5'd14,
        OP_DECR     = 5'd15,
        OP_SHL      = 5'd16,
        OP_SAR      = 5'd17,
        OP_SHR      = 5'd18,
        OP_RCL      = 5'd19,
        OP_RCR      = 5'd20,
        OP_BCDADJ   = 5'd21,
        OP_MUL      = 5'd22,
        OP_SEXT     = 5'd23
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0]  hi;
        logic [DW-1:0]  lo;
        logic [CCW-1:0] cc;
    } alu_res_t;

    // Write N and Z from a value, leave the rest of the byte alone.
    function automatic logic [CCW-1:0] put_nz(input logic [CCW-1:0] cc,
                                              input logic [DW-1:0]  v);
        logic [CCW-1:0] r;
        r       = cc;
        r[CC_N] = v[DW-1];
        r[CC_Z] = (v == '0);
        return r;
    endfunction

    // Signed overflow of x+y (sub=0) or x-y (sub=1) given the result r.
    function automatic logic signed_ovf(input logic sub,
                                        input logic [DW-1:0] x,
                                        input logic [DW-1:0] y,
                                        input logic [DW-1:0] r);
        logic same_in;
        same_in = (x[DW-1] == y[DW-1]);
        return (sub ? !same_in : same_in) && (r[DW-1] != x[DW-1]);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic           c_in,
    input  logic [CCW-1:0] cc_in,
    output alu_res_t       res,
    output logic           hit
);

    logic [DW-1:0]  x, y, r;
    logic           cy, sub, keep_c, set_h, ret_a;
    logic [DW:0]    wide;
    logic [NIB:0]   half;

    always_comb begin
        hit    = 1'b1;
        x      = opa;
        y      = opb;
        cy     = 1'b0;
        sub    = 1'b0;
        keep_c = 1'b0;
        set_h  = 1'b0;
        ret_a  = 1'b0;
        case (op)
            OP_ADD:    set_h = 1'b1;
            OP_ADDC:   begin cy = c_in; set_h = 1'b1; end
            OP_SUB:    sub = 1'b1;
            OP_SUBB:   begin sub = 1'b1; cy = c_in; end
            OP_CMP:    begin sub = 1'b1; ret_a = 1'b1; end
            OP_NEGATE: begin x = '0; y = opa; sub = 1'b1; end
            OP_INCR:   begin y = DW'(1); keep_c = 1'b1; end
            OP_DECR:   begin y = DW'(1); sub = 1'b1; keep_c = 1'b1; end
            default:   hit = 1'b0;
        endcase

        if (sub) wide = {1'b0, x} - {1'b0, y} - (DW+1)'(cy);
        else     wide = {1'b0, x} + {1'b0, y} + (DW+1)'(cy);
        half = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + (NIB+1)'(cy);
        r    = wide[DW-1:0];

        res.hi        = '0;
        res.lo        = ret_a ? opa : r;
        res.cc        = put_nz(cc_in, r);
        res.cc[CC_V]  = signed_ovf(sub, x, y, r);
        if (!keep_c) res.cc[CC_C] = wide[DW];
        if (set_h)   res.cc[CC_H] = half[NIB];
        if (!hit)    res = '0;
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic           c_in,
    input  logic [CCW-1:0] cc_in,
    output alu_res_t       res,
    output logic           hit
);

    logic [DW-1:0] val;     // value that drives N and Z
    logic [DW-1:0] outv;    // value returned
    logic          v_clr;   // V forced to 0
    logic          shl;     // left shift family: C/V from top bits
    logic          shr;     // right shift family: C from bit 0
    logic          c_set;

    always_comb begin
        hit   = 1'b1;
        v_clr = 1'b1;
        shl   = 1'b0;
        shr   = 1'b0;
        c_set = 1'b0;
        val   = opa;
        case (op)
            OP_AND:      val = opa & opb;
            OP_OR:       val = opa | opb;
            OP_XOR:      val = opa ^ opb;
            OP_TESTBITS: val = opa & opb;
            OP_PASS:     val = opb;
            OP_TEST:     val = opa;
            OP_CLEAR:    val = '0;
            OP_INVERT:   begin val = ~opa; c_set = 1'b1; end
            OP_SHL:      begin val = {opa[DW-2:0], 1'b0};     shl = 1'b1; v_clr = 1'b0; end
            OP_RCL:      begin val = {opa[DW-2:0], c_in};     shl = 1'b1; v_clr = 1'b0; end
            OP_SAR:      begin val = {opa[DW-1], opa[DW-1:1]}; shr = 1'b1; v_clr = 1'b0; end
            OP_SHR:      begin val = {1'b0, opa[DW-1:1]};     shr = 1'b1; v_clr = 1'b0; end
            OP_RCR:      begin val = {c_in, opa[DW-1:1]};     shr = 1'b1; v_clr = 1'b0; end
            default:     hit = 1'b0;
        endcase

        outv = ((op == OP_TESTBITS) || (op == OP_TEST)) ? opa : val;

        res.hi = '0;
        res.lo = outv;
        res.cc = put_nz(cc_in, val);
        if (v_clr) res.cc[CC_V] = 1'b0;
        if (shl) begin
            res.cc[CC_C] = opa[DW-1];
            res.cc[CC_V] = opa[DW-1] ^ opa[DW-2];
        end
        if (shr)   res.cc[CC_C] = opa[0];
        if (c_set) res.cc[CC_C] = 1'b1;
        if (op == OP_CLEAR) res.cc[CC_C] = 1'b0;
        if (!hit) res = '0;
    end

endmodule

// File: rtl/alu8_special.sv
module alu8_special
    import alu8_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic [CCW-1:0] cc_in,
    output alu_res_t       res,
    output logic           hit
);

    logic [NIB-1:0]  nib_lo, nib_hi;
    logic            fix_lo, fix_hi;
    logic [DW:0]     bcd_sum;
    logic [2*DW-1:0] prod;

    always_comb begin
        nib_lo  = opa[NIB-1:0];
        nib_hi  = opa[DW-1:NIB];
        fix_lo  = cc_in[CC_H] || (nib_lo > NIB'(9));
        fix_hi  = cc_in[CC_C] || (nib_hi > NIB'(9)) ||
                  ((nib_hi > NIB'(8)) && (nib_lo > NIB'(9)));
        bcd_sum = {1'b0, opa} + {1'b0, (fix_hi ? NIB'(6) : NIB'(0)),
                                       (fix_lo ? NIB'(6) : NIB'(0))};
        prod    = opa * opb;

        hit = 1'b1;
        res = '0;
        case (op)
            OP_BCDADJ: begin
                res.lo       = bcd_sum[DW-1:0];
                res.cc       = put_nz(cc_in, bcd_sum[DW-1:0]);
                res.cc[CC_C] = cc_in[CC_C] | bcd_sum[DW];
            end
            OP_MUL: begin
                res.hi       = prod[2*DW-1:DW];
                res.lo       = prod[DW-1:0];
                res.cc       = cc_in;
                res.cc[CC_Z] = (prod == '0);
                res.cc[CC_C] = prod[DW-1];
            end
            OP_SEXT: begin
                res.hi       = {DW{opa[DW-1]}};
                res.lo       = opa;
                res.cc       = put_nz(cc_in, opa);
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic           c_in,
    input  logic [CCW-1:0] cc_in,
    output logic [DW-1:0]  res_lo,
    output logic [DW-1:0]  res_hi,
    output logic [CCW-1:0] cc_out
);

    alu_op_e            op;
    alu_res_t           unit_res [NUNIT];
    alu_res_t           masked   [NUNIT];
    logic [NUNIT-1:0]   unit_hit;
    alu_res_t           merged;

    assign op = alu_op_e'(op_sel);

    alu8_arith u_arith (
        .op(op), .opa(opa), .opb(opb), .c_in(c_in), .cc_in(cc_in),
        .res(unit_res[0]), .hit(unit_hit[0])
    );

    alu8_logic u_logic (
        .op(op), .opa(opa), .opb(opb), .c_in(c_in), .cc_in(cc_in),
        .res(unit_res[1]), .hit(unit_hit[1])
    );

    alu8_special u_special (
        .op(op), .opa(opa), .opb(opb), .cc_in(cc_in),
        .res(unit_res[2]), .hit(unit_hit[2])
    );

    for (genvar k = 0; k < NUNIT; k++) begin : g_mask
        assign masked[k] = unit_hit[k] ? unit_res[k] : '0;
    end

    always_comb begin
        merged = '0;
        for (int k = 0; k < NUNIT; k++) merged = merged | masked[k];
        if (unit_hit == '0) merged.cc = cc_in;
    end

    assign res_lo = merged.lo;
    assign res_hi = merged.hi;
    assign cc_out = merged.cc;

    always_comb begin
        AST_ONE_UNIT: assert ($onehot0(unit_hit)) else $error("two units claim one code"); // R1
        AST_MASK_BITS_KEPT: assert (cc_out[CC_E] == cc_in[CC_E] && cc_out[CC_F] == cc_in[CC_F] &&
                                    cc_out[CC_I] == cc_in[CC_I]) else $error("mask bits changed"); // R14
        if (op_sel == OP_CLEAR)
            AST_CLEAR_FLAGS: assert (res_lo == '0 && cc_out[3:0] == 4'b0100) else $error("clear"); // R5
        if (op_sel == OP_INVERT)
            AST_INVERT_CARRY: assert (cc_out[CC_C] && ((res_lo ^ opa) == '1)) else $error("invert"); // R6
        if (op_sel == OP_INCR || op_sel == OP_DECR)
            AST_STEP_KEEPS_C: assert (cc_out[CC_C] == cc_in[CC_C]) else $error("step carry"); // R8
        if (op_sel == OP_MUL)
            AST_MUL_ZERO: assert (cc_out[CC_Z] == (opa == '0 || opb == '0)) else $error("mul zero"); // R12
        if (op_sel != OP_MUL && op_sel != OP_SEXT)
            AST_HI_IDLE: assert (res_hi == '0) else $error("high byte"); // R14
    end

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_sel;
    logic [7:0] opa, opb, cc_in;
    logic       c_in;
    logic [7:0] res_lo, res_hi, cc_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;

    alu8_core uut (
        .op_sel(op_sel), .opa(opa), .opb(opb), .c_in(c_in), .cc_in(cc_in),
        .res_lo(res_lo), .res_hi(res_hi), .cc_out(cc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(input int op);
        case (op)
            0, 1:        return "R2";
            2, 3, 4:     return "R3";
            5, 6, 7, 8, 9, 10: return "R4";
            11:          return "R5";
            12:          return "R6";
            13:          return "R7";
            14, 15:      return "R8";
            16, 19:      return "R9";
            17, 18, 20:  return "R10";
            21:          return "R11";
            22:          return "R12";
            23:          return "R13";
            default:     return "R1";
        endcase
    endfunction

    function automatic int setb(input int cc, input int pos, input int val);
        return (cc & ~(1 << pos)) | ((val != 0 ? 1 : 0) << pos);
    endfunction

    // Expected {res_hi, res_lo, cc_out}, from the requirement text.
    function automatic int model(input int op, input int a, input int b,
                                 input int ci, input int cc);
        int r, hi, c, s, fv, lo, hn;
        hi = 0; c = cc; r = 0;
        case (op)
            0, 1: begin
                s = a + b + ((op == 1) ? ci : 0);
                r = s & 255;
                c = setb(c, 5, ((a & 15) + (b & 15) + ((op == 1) ? ci : 0)) > 15);
                c = setb(c, 1, ((a ^ r) & (b ^ r) & 128) != 0);
                c = setb(c, 0, s > 255);
                fv = r;
            end
            2, 3, 4: begin
                s = a - b - ((op == 3) ? ci : 0);
                fv = s & 255;
                c = setb(c, 1, ((a ^ b) & (a ^ fv) & 128) != 0);
                c = setb(c, 0, s < 0);
                r = (op == 4) ? a : fv;
            end
            5, 6, 7, 8, 9, 10: begin
                case (op)
                    5: fv = a & b;
                    6: fv = a | b;
                    7: fv = a ^ b;
                    8: fv = a & b;
                    9: fv = b;
                    default: fv = a;
                endcase
                r = (op == 8 || op == 10) ? a : fv;
                c = setb(c, 1, 0);
            end
            11: begin r = 0; fv = 0; c = setb(c, 1, 0); c = setb(c, 0, 0); end
            12: begin r = (~a) & 255; fv = r; c = setb(c, 1, 0); c = setb(c, 0, 1); end
            13: begin r = (256 - a) & 255; fv = r; c = setb(c, 0, a != 0); c = setb(c, 1, a == 128); end
            14: begin r = (a + 1) & 255; fv = r; c = setb(c, 1, a == 127); end
            15: begin r = (a + 255) & 255; fv = r; c = setb(c, 1, a == 128); end
            16, 19: begin
                r = ((a << 1) | ((op == 19) ? ci : 0)) & 255; fv = r;
                c = setb(c, 0, a >= 128);
                c = setb(c, 1, ((a >> 7) ^ (a >> 6)) & 1);
            end
            17, 18, 20: begin
                r = a >> 1;
                if (op == 17) r = r | (a & 128);
                if (op == 20) r = r | (ci << 7);
                fv = r;
                c = setb(c, 0, a & 1);
            end
            21: begin
                lo = a & 15; hn = a >> 4;
                s = a + ((((cc >> 5) & 1) != 0 || lo > 9) ? 6 : 0)
                      + (((cc & 1) != 0 || hn > 9 || (hn > 8 && lo > 9)) ? 96 : 0);
                r = s & 255; fv = r;
                c = setb(c, 0, (cc & 1) != 0 || s > 255);
            end
            22: begin
                s = a * b; hi = s >> 8; r = s & 255;
                c = setb(c, 2, s == 0);
                c = setb(c, 0, (r >> 7) & 1);
                return (hi << 16) | (r << 8) | c;
            end
            23: begin hi = (a >= 128) ? 255 : 0; r = a; fv = a; end
            default: return cc;
        endcase
        c = setb(c, 3, (fv >> 7) & 1);
        c = setb(c, 2, fv == 0);
        return (hi << 16) | (r << 8) | c;
    endfunction

    task automatic run_vec(input int op, input int a, input int b,
                           input int ci, input int cc);
        int exp_v, act_v;
        op_sel = 5'(op); opa = 8'(a); opb = 8'(b); c_in = 1'(ci); cc_in = 8'(cc);
        #1;
        exp_v = model(op, a, b, ci, cc);
        act_v = {8'h00, res_hi, res_lo, cc_out};
        total++;
        if (act_v != exp_v) begin
            bad++;
            if (bad < 20)
                $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d cc=%02h actual=%06h expected=%06h",
                         req_of(op), op, a, b, ci, cc, act_v, exp_v);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int ccs [6];
        ccs = '{8'h00, 8'h01, 8'h20, 8'h21, 8'hFF, 8'hD4};
        op_sel = '0; opa = '0; opb = '0; c_in = 1'b0; cc_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 R3: full operand grid for add/sub/compare families
        for (int op = 0; op <= 4; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    run_vec(op, a, b, (a ^ (b >> 3)) & 1, (a * 7 + b) & 255);

        // R4: bitwise, bit test, pass, test on the full grid
        for (int op = 5; op <= 10; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    run_vec(op, a, b, b & 1, (a ^ (b << 1)) & 255);

        // R12: full multiply grid
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                run_vec(22, a, b, 0, (a + b * 3) & 255);

        // R5..R11, R13, R14: single-operand ops, all values, both carries, six cc patterns
        for (int op = 11; op <= 23; op++) begin
            if (op == 22) continue;
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++)
                    for (int k = 0; k < 6; k++)
                        run_vec(op, a, (a * 5) & 255, ci, ccs[k]);
        end

        // R1: unused codes leave the flags alone and return zero
        for (int op = 24; op < 32; op++)
            for (int k = 0; k < 16; k++)
                run_vec(op, k * 17, 255 - k, k & 1, (k * 29) & 255);

        finish_run();
    end

endmodule